// File: doc/BRIEF.md
# Auxiliary Serial-Audio to TDM Channel Aggregator

The aggregator gathers one internal stereo sample pair and three external stereo serial-audio (I2S) capture streams. It packs them into a single eight-slot time-division-multiplexed (TDM) frame for a host processor. In the other direction it unpacks an eight-slot TDM playback frame from the host into eight parallel playback words. All logic runs on the master clock. The TDM bit clock is the master clock divided by two, so one frame lasts 512 master-clock cycles and carries 256 TDM bits.

The three external streams share one auxiliary frame clock and one auxiliary bit clock. The auxiliary bit clock runs at 64 times the frame rate. In master mode the block generates these two clocks from the master clock, aligned to the TDM frame, and enables their pad drivers. In slave mode it takes them from pins, brings them into the master-clock domain through two-stage synchronizers, and leaves its clock outputs low and disabled.

Each outgoing slot is 32 bits long and carries a `DATA_W`-bit sample, MSB first, followed by zero bits. Samples captured during one frame are sent in the next frame.

Top module: `aux_tdm_aggregator`

## Requirements
- R1: `tdm_bclk` toggles on every master clock edge after reset, so it is the master clock divided by two. A frame is 512 master-clock cycles, which is 256 TDM bits numbered 0 to 255.
- R2: `tdm_fs` is high for exactly one TDM bit period, during bit 255 of each frame. It falls as bit 0 (the MSB of the first slot) of the next frame begins.
- R3: Outgoing slots 0 to 7 carry, in this order: internal left, external 1 left, external 2 left, external 3 left, internal right, external 1 right, external 2 right, external 3 right. Slot s holds TDM bits 32·s to 32·s+31.
- R4: Within a slot, bits 0 to `DATA_W`-1 are the sample MSB first, and the remaining bits are 0. `tdm_dout` changes only as `tdm_bclk` falls.
- R5: Words received on the external inputs during a frame, and the `int_left`/`int_right` values present at the frame's last master-clock cycle, appear in the TDM slots of the following frame. In master mode this latency is exactly one frame.
- R6: With `aux_master`=1: `aux_bclk_o` is the master clock divided by 8; `aux_lrclk_o` is the master clock divided by 512 and is low during the first half of each TDM frame; `aux_lrclk_o` changes only as `aux_bclk_o` falls; `aux_clk_oe`=1.
- R7: With `aux_master`=0: `aux_bclk_o`, `aux_lrclk_o` and `aux_clk_oe` are 0. Capture uses `aux_bclk_i`/`aux_lrclk_i`, and a steady external sample stream appears in its slots.
- R8: The external inputs follow I2S framing. Data is sampled on the rising auxiliary bit clock. The MSB comes one bit clock after the frame-clock edge. The left word is sent while the frame clock is low. Bits past the `DATA_W`-th in a word are ignored.
- R9: `tdm_din` is sampled on rising `tdm_bclk`. Slot s (playback L1..L4 in slots 0..3, R1..R4 in slots 4..7) is delivered MSB first in `play_data[s*DATA_W +: DATA_W]`. All eight words update together with a one-cycle `play_strobe` in the first master-clock cycle of the following frame. Slot bits past `DATA_W` are ignored.
- R10: While `rst` is high, `tdm_bclk`, `tdm_fs`, `tdm_dout`, `play_strobe` and `play_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_master | input | 1 | 1: generate auxiliary clocks, 0: take them from pins |
| int_left | input | DATA_W | Internal converter left sample |
| int_right | input | DATA_W | Internal converter right sample |
| aux_bclk_i | input | 1 | Auxiliary bit clock from pin (slave mode) |
| aux_lrclk_i | input | 1 | Auxiliary frame clock from pin (slave mode) |
| aux_din | input | N_AUX | Serial data of the external I2S streams |
| aux_bclk_o | output | 1 | Generated auxiliary bit clock |
| aux_lrclk_o | output | 1 | Generated auxiliary frame clock |
| aux_clk_oe | output | 1 | Pad enable for the auxiliary clock outputs |
| tdm_bclk | output | 1 | TDM bit clock |
| tdm_fs | output | 1 | TDM frame sync pulse |
| tdm_dout | output | 1 | TDM capture data to host |
| tdm_din | input | 1 | TDM playback data from host |
| play_data | output | 2*(N_AUX+1)*DATA_W | Eight playback words, slot 0 in the low bits |
| play_strobe | output | 1 | One-cycle pulse when play_data updates |

## Verification
Two things happen on the same master-clock edge at every frame boundary. The outgoing slot buffer reloads with the words captured in the ending frame, and the playback deserializer publishes its eight words. The bench drives fresh random and directed words on both paths in every frame, so a swapped or stale value on either side would show. It judges the outcome by rebuilding each outgoing slot from the sampled `tdm_dout` bits and comparing it with the previous frame's words. At that same first cycle it compares `play_data` and `play_strobe` with the previous frame's playback words.

// File: rtl/aux_tdm_aggregator.sv
module aux_tdm_aggregator #(
  parameter int DATA_W = 24,
  parameter int N_AUX  = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              aux_master,
  input  logic [DATA_W-1:0]                 int_left,
  input  logic [DATA_W-1:0]                 int_right,
  input  logic                              aux_bclk_i,
  input  logic                              aux_lrclk_i,
  input  logic [N_AUX-1:0]                  aux_din,
  output logic                              aux_bclk_o,
  output logic                              aux_lrclk_o,
  output logic                              aux_clk_oe,
  output logic                              tdm_bclk,
  output logic                              tdm_fs,
  output logic                              tdm_dout,
  input  logic                              tdm_din,
  output logic [2*(N_AUX+1)*DATA_W-1:0]     play_data,
  output logic                              play_strobe
);
  localparam int HALF    = N_AUX + 1;
  localparam int SLOTS   = 2 * HALF;
  localparam int SLOT_LG = $clog2(SLOTS);
  localparam int CNT_W   = SLOT_LG + 6;
  localparam int ADIV_LG = SLOT_LG;

  // frame position: [0] half bit, [5:1] bit in slot, upper bits slot
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk)
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;

  logic [SLOT_LG-1:0] slot;
  logic [4:0]         sbit;
  logic               frame_end;
  assign slot      = cnt[CNT_W-1:6];
  assign sbit      = cnt[5:1];
  assign frame_end = &cnt;

  assign tdm_bclk = cnt[0];
  assign tdm_fs   = &cnt[CNT_W-1:1];

  // auxiliary clock generation (master mode)
  logic m_bclk, m_lr, m_rise;
  assign m_bclk = cnt[ADIV_LG-1];
  assign m_lr   = cnt[CNT_W-1];
  assign m_rise = (cnt[ADIV_LG-1:0] == ADIV_LG'((1 << (ADIV_LG-1)) - 1));

  assign aux_bclk_o  = aux_master & m_bclk;
  assign aux_lrclk_o = aux_master & m_lr;
  assign aux_clk_oe  = aux_master;

  // slave-mode synchronizers
  logic [2:0]       s_bclk;
  logic [1:0]       s_lr;
  logic [N_AUX-1:0] s_d1, s_d2;
  always_ff @(posedge clk)
    if (rst) begin
      s_bclk <= '0;
      s_lr   <= '0;
      s_d1   <= '0;
      s_d2   <= '0;
    end else begin
      s_bclk <= {s_bclk[1:0], aux_bclk_i};
      s_lr   <= {s_lr[0], aux_lrclk_i};
      s_d1   <= aux_din;
      s_d2   <= s_d1;
    end

  logic             smp, lr_now;
  logic [N_AUX-1:0] din_now;
  assign smp     = aux_master ? m_rise  : (s_bclk[1] & ~s_bclk[2]);
  assign lr_now  = aux_master ? m_lr    : s_lr[1];
  assign din_now = aux_master ? aux_din : s_d2;

  // shared I2S bit tracking
  logic       lr_prev;
  logic [5:0] bitcnt;
  logic       capture, word_done;
  assign capture   = smp && (lr_now == lr_prev) && (int'(bitcnt) < DATA_W);
  assign word_done = capture && (int'(bitcnt) == DATA_W - 1);

  always_ff @(posedge clk)
    if (rst) begin
      lr_prev <= 1'b0;
      bitcnt  <= 6'(DATA_W);
    end else if (smp) begin
      lr_prev <= lr_now;
      if (lr_now != lr_prev) bitcnt <= '0;
      else if (int'(bitcnt) < DATA_W) bitcnt <= bitcnt + 1'b1;
    end

  logic [DATA_W-1:0] sh     [N_AUX];
  logic [DATA_W-1:0] lw     [N_AUX];
  logic [DATA_W-1:0] hold_l [N_AUX];
  logic [DATA_W-1:0] hold_r [N_AUX];

  always_ff @(posedge clk)
    if (rst) begin
      for (int i = 0; i < N_AUX; i++) begin
        sh[i]     <= '0;
        lw[i]     <= '0;
        hold_l[i] <= '0;
        hold_r[i] <= '0;
      end
    end else if (capture) begin
      for (int i = 0; i < N_AUX; i++) begin
        sh[i] <= {sh[i][DATA_W-2:0], din_now[i]};
        if (word_done && !lr_prev) lw[i] <= {sh[i][DATA_W-2:0], din_now[i]};
        if (word_done && lr_prev) begin
          hold_l[i] <= lw[i];
          hold_r[i] <= {sh[i][DATA_W-2:0], din_now[i]};
        end
      end
    end

  // outgoing frame buffer
  logic [DATA_W-1:0] obuf [SLOTS];
  always_ff @(posedge clk)
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) obuf[s] <= '0;
    end else if (frame_end) begin
      obuf[0]    <= int_left;
      obuf[HALF] <= int_right;
      for (int i = 0; i < N_AUX; i++) begin
        obuf[1+i]      <= hold_l[i];
        obuf[HALF+1+i] <= hold_r[i];
      end
    end

  logic [DATA_W-1:0] cur;
  logic [4:0]        didx;
  assign cur      = obuf[slot];
  assign didx     = 5'(DATA_W - 1) - sbit;
  assign tdm_dout = (int'(sbit) < DATA_W) ? cur[didx] : 1'b0;

  // incoming playback frame
  logic [DATA_W-1:0] psh [SLOTS];
  always_ff @(posedge clk)
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) psh[s] <= '0;
      play_data   <= '0;
      play_strobe <= 1'b0;
    end else begin
      if (!cnt[0] && int'(sbit) < DATA_W)
        psh[slot] <= {psh[slot][DATA_W-2:0], tdm_din};
      if (frame_end)
        for (int s = 0; s < SLOTS; s++) play_data[s*DATA_W +: DATA_W] <= psh[s];
      play_strobe <= frame_end;
    end

  AST_BCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (tdm_bclk != $past(tdm_bclk))); // R1
  AST_FS_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $rose(tdm_fs) |=> tdm_fs); // R2
  AST_FS_ENDS: assert property (@(posedge clk) disable iff (rst)
    (tdm_fs && $past(tdm_fs)) |=> !tdm_fs); // R2
  AST_AUX_LR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (aux_master && $past(aux_master) && $past(!rst) && (aux_lrclk_o != $past(aux_lrclk_o)))
      |-> $fell(aux_bclk_o)); // R6
  AST_STROBE_AFTER_FS: assert property (@(posedge clk) disable iff (rst)
    play_strobe |-> ($past(tdm_fs) && !tdm_fs)); // R9
  AST_FS_FALL_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(tdm_fs) |-> play_strobe); // R9
endmodule

// File: tb/aux_tdm_aggregator_tb_top.sv
module aux_tdm_aggregator_tb_top;
  localparam int DATA_W = 24;
  localparam int N_AUX  = 3;
  localparam int HALF   = N_AUX + 1;
  localparam int SLOTS  = 2 * HALF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, aux_master, aux_bclk_i, aux_lrclk_i, tdm_din;
  logic [DATA_W-1:0] int_left, int_right;
  logic [N_AUX-1:0] aux_din;
  logic aux_bclk_o, aux_lrclk_o, aux_clk_oe, tdm_bclk, tdm_fs, tdm_dout, play_strobe;
  logic [SLOTS*DATA_W-1:0] play_data;

  aux_tdm_aggregator #(.DATA_W(DATA_W), .N_AUX(N_AUX)) dut_i (
    .clk(clk), .rst(rst), .aux_master(aux_master),
    .int_left(int_left), .int_right(int_right),
    .aux_bclk_i(aux_bclk_i), .aux_lrclk_i(aux_lrclk_i), .aux_din(aux_din),
    .aux_bclk_o(aux_bclk_o), .aux_lrclk_o(aux_lrclk_o), .aux_clk_oe(aux_clk_oe),
    .tdm_bclk(tdm_bclk), .tdm_fs(tdm_fs), .tdm_dout(tdm_dout), .tdm_din(tdm_din),
    .play_data(play_data), .play_strobe(play_strobe)
  );

  int total = 0;
  int bad   = 0;

  logic [DATA_W-1:0] al [N_AUX];
  logic [DATA_W-1:0] ar [N_AUX];
  logic [DATA_W-1:0] pw [SLOTS];
  logic [DATA_W-1:0] pprev [SLOTS];
  logic [DATA_W-1:0] expc [SLOTS];
  logic [DATA_W-1:0] obs [SLOTS];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rword();
    return DATA_W'($urandom);
  endfunction

  // fill all words: 0 random, 1 all ones, 2 alternating, 3 zeros
  task automatic fill(input int kind);
    for (int i = 0; i < N_AUX; i++) begin
      al[i] = (kind == 0) ? rword() : (kind == 1) ? '1 : (kind == 2) ? DATA_W'(24'hA5A5A5) : '0;
      ar[i] = (kind == 0) ? rword() : (kind == 1) ? '1 : (kind == 2) ? DATA_W'(24'h5A5A5A) : '0;
    end
    int_left  = (kind == 0) ? rword() : (kind == 1) ? '1 : (kind == 2) ? DATA_W'(24'h5A5A5A) : '0;
    int_right = (kind == 0) ? rword() : (kind == 1) ? '1 : (kind == 2) ? DATA_W'(24'hA5A5A5) : '0;
    for (int s = 0; s < SLOTS; s++)
      pw[s] = (kind == 0) ? rword() : (kind == 1) ? '1 : (kind == 2) ? DATA_W'(24'hC3C3C3) : '0;
  endtask

  // called at the negedge where the design is at frame position 0
  task automatic run_frame(input bit master, input int ph, input bit chkd);
    int eb = 0, efs = 0, eaux = 0, estb = 0, pad = 0, odd = 0;
    logic last = 1'b0;
    logic [DATA_W-1:0] expn [SLOTS];
    aux_master = master;
    expn[0]    = int_left;
    expn[HALF] = int_right;
    for (int i = 0; i < N_AUX; i++) begin
      expn[1+i]      = al[i];
      expn[HALF+1+i] = ar[i];
    end
    for (int pos = 0; pos < 512; pos++) begin
      int ap, j, hf, k, n, s, b;
      ap = (pos + ph) % 512;
      aux_bclk_i  = ap[2];
      aux_lrclk_i = ap[8];
      j  = ap >> 3;
      hf = j >> 5;
      k  = j & 31;
      for (int i = 0; i < N_AUX; i++) begin
        if (k >= 1 && k - 1 < DATA_W) aux_din[i] = hf ? ar[i][DATA_W-k] : al[i][DATA_W-k];
        else if ((ap & 7) == 0)       aux_din[i] = 1'($urandom);
      end
      n = pos >> 1;
      s = n >> 5;
      b = n & 31;
      if ((pos & 1) == 0) begin
        tdm_din = (b < DATA_W) ? pw[s][DATA_W-1-b] : 1'($urandom);
        if (b < DATA_W) obs[s][DATA_W-1-b] = tdm_dout;
        else if (tdm_dout) pad++;
        last = tdm_dout;
      end else if (tdm_dout != last) odd++;
      if (tdm_bclk != 1'(pos & 1)) eb++;
      if (tdm_fs != (pos >= 510)) efs++;
      if (master) begin
        if (aux_bclk_o != ap[2] || aux_lrclk_o != ap[8] || !aux_clk_oe) eaux++;
      end else if (aux_bclk_o || aux_lrclk_o || aux_clk_oe) eaux++;
      if (play_strobe != (pos == 0)) estb++;
      if (pos == 0)
        for (int q = 0; q < SLOTS; q++)
          chk(play_data[q*DATA_W +: DATA_W] == pprev[q], $sformatf("R9 play slot %0d", q),
              64'(play_data[q*DATA_W +: DATA_W]), 64'(pprev[q]));
      @(negedge clk);
    end
    chk(eb == 0, "R1 bit clock phase", 64'(eb), 0);
    chk(efs == 0, "R2 frame sync position", 64'(efs), 0);
    chk(eaux == 0, master ? "R6 master aux clocks" : "R7 slave aux outputs quiet", 64'(eaux), 0);
    chk(estb == 0, "R9 strobe timing", 64'(estb), 0);
    chk(pad == 0 && odd == 0, "R4 zero padding and falling-edge change", 64'(pad + odd), 0);
    if (chkd)
      for (int q = 0; q < SLOTS; q++)
        chk(obs[q] == expc[q], $sformatf("R3 R5 R8 slot %0d", q), 64'(obs[q]), 64'(expc[q]));
    if (master)
      for (int q = 0; q < SLOTS; q++) expc[q] = expn[q];
    for (int q = 0; q < SLOTS; q++) pprev[q] = pw[q];
  endtask

  initial begin
    void'($urandom(32'd91357));
    rst = 1'b1; aux_master = 1'b1; aux_bclk_i = 1'b0; aux_lrclk_i = 1'b0;
    aux_din = '0; tdm_din = 1'b0; int_left = '0; int_right = '0;
    fill(3);
    for (int s = 0; s < SLOTS; s++) begin pprev[s] = '0; expc[s] = '0; end
    repeat (4) @(negedge clk);
    chk(!tdm_bclk && !tdm_fs && !tdm_dout && !play_strobe && play_data == '0,
        "R10 reset outputs", {60'd0, tdm_bclk, tdm_fs, tdm_dout, play_strobe}, 0);
    rst = 1'b0;
    do @(negedge clk); while (!tdm_fs);
    do @(negedge clk); while (tdm_fs);
    for (int f = 0; f < 12; f++) begin
      fill(f == 2 ? 1 : f == 3 ? 2 : f == 4 ? 3 : 0);
      run_frame(1'b1, 0, 1'b1);
    end
    // slave mode: steady stream with an offset clock phase
    fill(0);
    for (int f = 0; f < 6; f++) begin
      if (f == 5) begin
        expc[0] = int_left; expc[HALF] = int_right;
        for (int i = 0; i < N_AUX; i++) begin expc[1+i] = al[i]; expc[HALF+1+i] = ar[i]; end
      end
      for (int s = 0; s < SLOTS; s++) pw[s] = rword();
      run_frame(1'b0, 3, (f == 0) || (f == 5));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule